// File: doc/BRIEF.md
# Serial-Bus ROM Command Layer

This block sits between a single-wire bit-slot engine and a memory-function layer. After every bus reset it waits for an 8-bit ROM command, received least significant bit first, and then handles the device-addressing step. Depending on the command it sends out its 64-bit identity, compares an incoming identity, runs the three-slot search arbitration, or simply grants access. It also keeps the overdrive-speed flag.

The bit-slot engine talks to the block one bit at a time. A one-cycle `rx_valid_i` pulse delivers a bit the master has written. A one-cycle `rd_slot_i` pulse marks a read slot, and `tx_bit_o` must be valid during it. A one-cycle `bus_reset_i` pulse reports a bus reset, and `reset_long_i` gives that reset's length class. When addressing succeeds, `mem_en_o` hands control to the memory layer until the next reset. When it fails, the block releases the line (drives 1) and ignores all slots until a reset arrives.

Top module: `rom_cmd_layer`

## Requirements
- R1: After `rst_ni` is released, `od_o`=0, `mem_en_o`=0 and `tx_bit_o`=1, and the block waits for a command byte.
- R2: The identity holds the `FAMILY` parameter in bits 7:0, the `SERIAL` parameter in bits 55:8, and in bits 63:56 a CRC over bits 55:0. The CRC uses x^8+x^5+x^4+1, starts from zero and is shifted in bit 0 first. Shifting all 64 bits through the same generator leaves zero.
- R3: Command 0x33: the next 64 read slots return identity bit i in slot i, starting with bit 0. One cycle after the 64th slot, `mem_en_o` is 1.
- R4: Command 0xCC: one cycle after the 8th command bit, `mem_en_o` is 1 and `od_o` is unchanged. Later write slots are ignored until a bus reset; for example, a following 0x3C byte leaves `od_o` at 0.
- R5: Command 0x55: 64 written bits are compared with identity bits 0..63 in order. If all are equal, `mem_en_o` is 1 one cycle after the last bit. On the first differing bit the block drops out: `mem_en_o` stays 0, read slots return 1, and this lasts until a bus reset.
- R6: Command 0xF0: each identity bit i takes three slots, in this order: a read slot returning bit i, a read slot returning its complement, and a write slot carrying the master's choice. A choice that differs from bit i drops the block out, as in R5. Finishing all 64 bits sets `mem_en_o`.
- R7: Command 0x3C: one cycle after the 8th command bit, both `od_o` and `mem_en_o` are 1.
- R8: Command 0x69: a full 64-bit match sets both `od_o` and `mem_en_o`. A mismatch leaves `od_o` at its previous value, whether that was 0 or 1.
- R9: A bus reset with `reset_long_i`=1 clears `od_o`. A bus reset with `reset_long_i`=0 leaves `od_o` unchanged.
- R10: Any other command code drops the block out: read slots return 1 and `mem_en_o` stays 0.
- R11: A bus reset at any point clears `mem_en_o`, abandons the current command, and restarts reception of the command byte and the identity bit index from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset seen |
| reset_long_i | input | 1 | With `bus_reset_i`: 1 if the reset was long (regular-speed length) |
| rx_valid_i | input | 1 | One-cycle pulse: a write slot delivered `rx_bit_i` |
| rx_bit_i | input | 1 | Bit written by the master |
| rd_slot_i | input | 1 | One-cycle pulse: a read slot consumes `tx_bit_o` |
| tx_bit_o | output | 1 | Bit to present in the current read slot (1 = released) |
| od_o | output | 1 | Overdrive-speed flag |
| mem_en_o | output | 1 | Memory-function layer enabled |

## Verification
`tx_bit_o` is combinational from the current state, so it is due in the same cycle as the `rd_slot_i` pulse. The bench samples it one nanosecond after the falling edge on which it raised that pulse. `od_o` and `mem_en_o` are registered and change on the rising edge that consumes the final bit of a command, an identity or a reset pulse. The bench therefore reads them only after its driver task has passed that edge and reached the next falling edge. Expected read-slot bits are queued by the driver at the moment each slot is issued, which keeps every comparison paired with the slot it belongs to.

// File: rtl/rom_cmd_pkg.sv
`timescale 1ns/1ps
package rom_cmd_pkg;
  localparam int unsigned FAM_W = 8;
  localparam int unsigned SER_W = 48;
  localparam int unsigned CRC_W = 8;
  localparam int unsigned ID_W  = FAM_W + SER_W + CRC_W;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned IDX_W = $clog2(ID_W);

  localparam logic [CMD_W-1:0] OP_READ     = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] OP_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] OP_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] OP_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_MEM, ST_IDLE
  } rom_state_e;

  typedef enum logic [1:0] {PH_TRUE, PH_CMPL, PH_DIR} srch_phase_e;

  // reflected form of x^8+x^5+x^4+1, bit 0 shifted in first
  function automatic logic [CRC_W-1:0] rom_crc8(input logic [ID_W-CRC_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < int'(ID_W - CRC_W); i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction
endpackage

// File: rtl/rom_cmd_shift.sv
`timescale 1ns/1ps
module rom_cmd_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_nxt_o,
  output logic         last_o
);
  localparam int unsigned CNT_W = $clog2(W);

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;

  assign byte_nxt_o = {bit_i, sr_q[W-1:1]};
  assign last_o     = (cnt_q == CNT_W'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= byte_nxt_o;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rom_id_src.sv
`timescale 1ns/1ps
module rom_id_src
  import rom_cmd_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h3A,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_5C19_A7E2
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  localparam logic [ID_W-1:0] ID_VAL = {rom_crc8({SERIAL, FAMILY}), SERIAL, FAMILY};

  assign bit_o = ID_VAL[idx_i];
endmodule

// File: rtl/rom_ctrl_fsm.sv
`timescale 1ns/1ps
module rom_ctrl_fsm
  import rom_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             reset_long_i,
  input  logic             rx_valid_i,
  input  logic             rx_bit_i,
  input  logic             rd_slot_i,
  input  logic [CMD_W-1:0] byte_nxt_i,
  input  logic             byte_last_i,
  input  logic             id_bit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             shift_en_o,
  output logic             shift_clr_o,
  output logic             tx_bit_o,
  output logic             od_o,
  output logic             mem_en_o
);
  rom_state_e       state_q, state_d;
  srch_phase_e      ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             odm_q, odm_d;
  logic             od_q, od_d;
  logic             men_q, men_d;
  logic             idx_last;

  assign idx_last    = (idx_q == IDX_W'(ID_W - 1));
  assign idx_o       = idx_q;
  assign shift_clr_o = bus_reset_i;
  assign shift_en_o  = rx_valid_i && !bus_reset_i && (state_q == ST_CMD);
  assign od_o        = od_q;
  assign mem_en_o    = men_q;

  always_comb begin
    tx_bit_o = 1'b1;
    case (state_q)
      ST_READ:   tx_bit_o = id_bit_i;
      ST_SEARCH: begin
        if (ph_q == PH_TRUE)      tx_bit_o = id_bit_i;
        else if (ph_q == PH_CMPL) tx_bit_o = ~id_bit_i;
      end
      default:   tx_bit_o = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    idx_d   = idx_q;
    odm_d   = odm_q;
    od_d    = od_q;
    men_d   = men_q;
    if (bus_reset_i) begin
      state_d = ST_CMD;
      ph_d    = PH_TRUE;
      idx_d   = '0;
      odm_d   = 1'b0;
      men_d   = 1'b0;
      if (reset_long_i) od_d = 1'b0;
    end else begin
      case (state_q)
        ST_CMD: if (rx_valid_i && byte_last_i) begin
          idx_d = '0;
          ph_d  = PH_TRUE;
          case (byte_nxt_i)
            OP_READ:     state_d = ST_READ;
            OP_MATCH:    begin state_d = ST_MATCH; odm_d = 1'b0; end
            OP_OD_MATCH: begin state_d = ST_MATCH; odm_d = 1'b1; end
            OP_SEARCH:   state_d = ST_SEARCH;
            OP_SKIP:     begin state_d = ST_MEM; men_d = 1'b1; end
            OP_OD_SKIP:  begin state_d = ST_MEM; men_d = 1'b1; od_d = 1'b1; end
            default:     state_d = ST_IDLE;
          endcase
        end
        ST_READ: if (rd_slot_i) begin
          idx_d = idx_q + 1'b1;
          if (idx_last) begin
            state_d = ST_MEM;
            men_d   = 1'b1;
          end
        end
        ST_MATCH: if (rx_valid_i) begin
          if (rx_bit_i != id_bit_i) begin
            state_d = ST_IDLE;
          end else if (idx_last) begin
            state_d = ST_MEM;
            men_d   = 1'b1;
            if (odm_q) od_d = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_SEARCH: begin
          case (ph_q)
            PH_TRUE: if (rd_slot_i) ph_d = PH_CMPL;
            PH_CMPL: if (rd_slot_i) ph_d = PH_DIR;
            default: if (rx_valid_i) begin
              if (rx_bit_i != id_bit_i) begin
                state_d = ST_IDLE;
              end else if (idx_last) begin
                state_d = ST_MEM;
                men_d   = 1'b1;
              end else begin
                idx_d = idx_q + 1'b1;
                ph_d  = PH_TRUE;
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      ph_q    <= PH_TRUE;
      idx_q   <= '0;
      odm_q   <= 1'b0;
      od_q    <= 1'b0;
      men_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      odm_q   <= odm_d;
      od_q    <= od_d;
      men_q   <= men_d;
    end
  end
endmodule

// File: rtl/rom_cmd_layer.sv
`timescale 1ns/1ps
module rom_cmd_layer
  import rom_cmd_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h3A,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_5C19_A7E2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic reset_long_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic rd_slot_i,
  output logic tx_bit_o,
  output logic od_o,
  output logic mem_en_o
);
  logic [CMD_W-1:0] byte_nxt;
  logic             byte_last;
  logic             shift_en;
  logic             shift_clr;
  logic [IDX_W-1:0] idx;
  logic             id_bit;

  rom_cmd_shift #(.W(CMD_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (shift_clr),
    .shift_i    (shift_en),
    .bit_i      (rx_bit_i),
    .byte_nxt_o (byte_nxt),
    .last_o     (byte_last)
  );

  rom_id_src #(.FAMILY(FAMILY), .SERIAL(SERIAL)) i_id (
    .idx_i (idx),
    .bit_o (id_bit)
  );

  rom_ctrl_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_reset_i  (bus_reset_i),
    .reset_long_i (reset_long_i),
    .rx_valid_i   (rx_valid_i),
    .rx_bit_i     (rx_bit_i),
    .rd_slot_i    (rd_slot_i),
    .byte_nxt_i   (byte_nxt),
    .byte_last_i  (byte_last),
    .id_bit_i     (id_bit),
    .idx_o        (idx),
    .shift_en_o   (shift_en),
    .shift_clr_o  (shift_clr),
    .tx_bit_o     (tx_bit_o),
    .od_o         (od_o),
    .mem_en_o     (mem_en_o)
  );
endmodule

// File: rtl/rom_cmd_layer_chk.sv
`timescale 1ns/1ps
module rom_cmd_layer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic reset_long_i,
  input logic tx_bit_o,
  input logic od_o,
  input logic mem_en_o
);
  // R11
  rst_drops_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !mem_en_o);

  // R9
  long_rst_clears_od_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && reset_long_i) |=> !od_o);

  // R9
  short_rst_keeps_od_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && !reset_long_i) |=> (od_o == $past(od_o)));

  // R9
  od_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_o && !bus_reset_i) |=> od_o);

  // R7
  od_rise_grants_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(od_o) |-> mem_en_o);

  // R4
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !bus_reset_i) |=> mem_en_o);

  // R4
  mem_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> tx_bit_o);
endmodule

bind rom_cmd_layer rom_cmd_layer_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_reset_i  (bus_reset_i),
  .reset_long_i (reset_long_i),
  .tx_bit_o     (tx_bit_o),
  .od_o         (od_o),
  .mem_en_o     (mem_en_o)
);

// File: tb/test_rom_cmd_layer.sv
`timescale 1ns/1ps
module test_rom_cmd_layer;
  localparam logic [7:0]  FAM = 8'h3A;
  localparam logic [47:0] SER = 48'h0000_5C19_A7E2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_reset_i = 1'b0, reset_long_i = 1'b0;
  logic rx_valid_i = 1'b0, rx_bit_i = 1'b0, rd_slot_i = 1'b0;
  logic tx_bit_o, od_o, mem_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];
  logic [63:0] id_exp;

  always #2 clk = ~clk;

  rom_cmd_layer #(.FAMILY(FAM), .SERIAL(SER)) i_rom_cmd_layer (
    .clk_i(clk), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i), .reset_long_i(reset_long_i),
    .rx_valid_i(rx_valid_i), .rx_bit_i(rx_bit_i), .rd_slot_i(rd_slot_i),
    .tx_bit_o(tx_bit_o), .od_o(od_o), .mem_en_o(mem_en_o)
  );

  function automatic logic [7:0] tb_crc(input logic [63:0] d, input int n);
    logic [7:0] s;
    logic fb;
    s = 8'h00;
    for (int i = 0; i < n; i++) begin
      fb = s[0] ^ d[i];
      s = {fb, s[7:1]};
      s[3] = s[3] ^ fb;
      s[2] = s[2] ^ fb;
    end
    return s;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops queued read-slot expectations
  initial forever begin
    @(negedge clk);
    #1;
    if (rd_slot_i) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: actual %b expected none", tx_bit_o);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (tx_bit_o !== e) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b", t, tx_bit_o, e);
        end
      end
    end
  end

  task automatic wslot(input logic b);
    @(negedge clk); rx_valid_i = 1'b1; rx_bit_i = b;
    @(negedge clk); rx_valid_i = 1'b0;
  endtask

  task automatic rslot(input bit e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_slot_i = 1'b1;
    @(negedge clk); rd_slot_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) wslot(b[i]);
  endtask

  task automatic bus_rst(input logic lng);
    @(negedge clk); bus_reset_i = 1'b1; reset_long_i = lng;
    @(negedge clk); bus_reset_i = 1'b0; reset_long_i = 1'b0;
  endtask

  task automatic status(input string t, input logic od_e, input logic men_e);
    #1;
    check({t, " od"}, od_o, od_e);
    check({t, " mem_en"}, mem_en_o, men_e);
  endtask

  task automatic match_id(input logic [7:0] op, input int bad);
    send_byte(op);
    for (int i = 0; i < 64; i++) wslot(i == bad ? ~id_exp[i] : id_exp[i]);
  endtask

  initial begin
    id_exp = {tb_crc({8'h00, SER, FAM}, 56), SER, FAM};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1 od", od_o, 1'b0);
    check("R1 mem_en", mem_en_o, 1'b0);
    check("R1 tx", tx_bit_o, 1'b1);
    check("R2 residue", tb_crc(id_exp, 64) == 8'h00, 1'b1);

    // R3 read identity, CRC bits tagged R2
    bus_rst(1'b1);
    send_byte(8'h33);
    for (int i = 0; i < 64; i++) rslot(id_exp[i], i >= 56 ? "R2 crc bit" : "R3 id bit");
    status("R3", 1'b0, 1'b1);

    // R4 skip, later bytes ignored
    bus_rst(1'b1);
    status("R11", 1'b0, 1'b0);
    send_byte(8'hCC);
    status("R4", 1'b0, 1'b1);
    send_byte(8'h3C);
    status("R4 ignore", 1'b0, 1'b1);

    // R5 match good / bad
    bus_rst(1'b1);
    match_id(8'h55, -1);
    status("R5 good", 1'b0, 1'b1);
    bus_rst(1'b1);
    match_id(8'h55, 20);
    status("R5 bad", 1'b0, 1'b0);
    rslot(1'b1, "R5 dropped");

    // R6 search full / drop at bit 5
    bus_rst(1'b1);
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rslot(id_exp[i], "R6 true");
      rslot(~id_exp[i], "R6 cmpl");
      wslot(id_exp[i]);
    end
    status("R6 done", 1'b0, 1'b1);
    bus_rst(1'b1);
    send_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      rslot(id_exp[i], "R6 true");
      rslot(~id_exp[i], "R6 cmpl");
      wslot(i == 5 ? ~id_exp[i] : id_exp[i]);
    end
    rslot(1'b1, "R6 dropped");
    rslot(1'b1, "R6 dropped");
    status("R6 drop", 1'b0, 1'b0);

    // R7 overdrive skip, R9 reset length
    bus_rst(1'b1);
    send_byte(8'h3C);
    status("R7", 1'b1, 1'b1);
    bus_rst(1'b0);
    status("R9 short", 1'b1, 1'b0);
    bus_rst(1'b1);
    status("R9 long", 1'b0, 1'b0);

    // R8 overdrive match
    match_id(8'h69, -1);
    status("R8 good", 1'b1, 1'b1);
    bus_rst(1'b1);
    match_id(8'h69, 0);
    status("R8 bad slow", 1'b0, 1'b0);
    bus_rst(1'b1);
    send_byte(8'h3C);
    bus_rst(1'b0);
    match_id(8'h69, 63);
    status("R8 bad fast", 1'b1, 1'b0);

    // R10 unknown command
    bus_rst(1'b1);
    send_byte(8'hA5);
    rslot(1'b1, "R10 idle");
    status("R10", 1'b0, 1'b0);

    // R11 reset mid command and mid identity
    bus_rst(1'b1);
    for (int i = 0; i < 4; i++) wslot(1'b1);
    bus_rst(1'b1);
    send_byte(8'hCC);
    status("R11 cmd", 1'b0, 1'b1);
    bus_rst(1'b1);
    send_byte(8'h33);
    for (int i = 0; i < 10; i++) rslot(id_exp[i], "R3 id bit");
    bus_rst(1'b1);
    send_byte(8'h33);
    rslot(id_exp[0], "R11 idx restart");
    rslot(id_exp[1], "R11 idx restart");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule